// File: doc/BRIEF.md
# Write-Slot Reservation Queue with Merged Scoreboard

This block schedules register write-back for an in-order issue stage whose execution units all have fixed latencies. It holds a short queue in which each entry stands for one future clock cycle. Each entry has two write-back slots. An issuing instruction reserves one or two slots in the entry that matches its latency, and it tags each reserved slot with a destination register. The queue moves one entry toward the head on every clock edge. The head entry tells the register file which registers to write in the current cycle, and it is then dropped.

The same storage also acts as the register scoreboard. A register is reported busy while any valid slot anywhere in the queue names it, so no separate busy-bit array is needed. The issue stage presents one request at a time on a valid/ready handshake. Ready is a pure function of the queue state and of the request fields, never of valid. A request is taken only in a cycle where valid and ready are both high. While ready is low, the issue stage holds the instruction and tries again in a later cycle, with the same or different fields. Nothing else in the block back-pressures.

Latency is counted against the queue after its shift. A request taken in cycle c with latency L lands in the entry that sits at index L after the coming edge, so it appears on the write-back port in cycle c+L+1.

Top module: `wslot_sched_queue`

## Requirements
- R1: After reset both write-back ports are invalid and every bit of busy_map is 0.
- R2: For iss_lat below DEPTH (12), the target is the entry now at index iss_lat+1, or an empty entry when iss_lat is DEPTH-1. A one-slot request (iss_two=0) is ready when at least one slot of the target is free. A two-slot request (iss_two=1) is ready only when both slots of the target are free. An accepted request never overwrites a valid slot.
- R3: When iss_lat is DEPTH or larger, iss_ready is 0 and nothing is reserved.
- R4: An accepted one-slot request writes iss_dst0 into slot 0 when slot 0 is free, and into slot 1 otherwise.
- R5: An accepted two-slot request writes iss_dst0 into slot 0 and iss_dst1 into slot 1 of the same entry.
- R6: A request accepted in cycle c with latency L appears on its write-back port (wb0 for slot 0, wb1 for slot 1) in cycle c+L+1, exactly once.
- R7: busy_map[r] is 1 exactly while some valid slot in the queue, the head included, names register r. A register written back from the head is therefore free in the following cycle.
- R8: While iss_valid is 0, nothing is reserved, although iss_ready is still reported.
- R9: wb1_valid is never 1 while wb0_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_two | input | 1 | 1: request two slots; 0: request one slot |
| iss_lat | input | 4 | Latency index of the request |
| iss_dst0 | input | 6 | Primary destination register |
| iss_dst1 | input | 6 | Second destination register (used only when iss_two=1) |
| iss_ready | output | 1 | Request can be accepted this cycle |
| wb0_valid | output | 1 | Head slot 0 writes back this cycle |
| wb0_reg | output | 6 | Register index for head slot 0 |
| wb1_valid | output | 1 | Head slot 1 writes back this cycle |
| wb1_reg | output | 6 | Register index for head slot 1 |
| busy_map | output | 64 | One bit per register, 1 while a write to it is pending |

## Verification
The bench aims at three situations: a latency whose target entry is half full, a latency whose target entry is full, and a latency one past the deepest entry. A design that got these wrong would hand out a taken slot, refuse a free one, or reserve into an entry that does not exist. It also issues requests back to back at latencies one apart. Those requests meet in the same physical entry after one shift, so an off-by-one in the target index shows up as a collision or as a write-back in the wrong cycle. Random traffic reuses a small set of register numbers. This exposes a scoreboard that clears too early, for example when one of two pending writes to the same register retires, or that keeps a register busy for a cycle after its write-back.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  parameter int unsigned WSQ_NREGS = 64;
  localparam int unsigned WSQ_REG_W = $clog2(WSQ_NREGS);

  typedef struct packed {
    logic                 valid;
    logic [WSQ_REG_W-1:0] rd;
  } wslot_t;

  typedef struct packed {
    wslot_t s1;
    wslot_t s0;
  } wentry_t;
endpackage

// File: rtl/wsq_store.sv
module wsq_store
  import wsq_pkg::*;
#(
  parameter int unsigned DEPTH = 12,
  localparam int unsigned LAT_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic [LAT_W-1:0]     alloc_idx,
  input  logic                 use_s0,
  input  logic                 use_s1,
  input  logic [WSQ_REG_W-1:0] rd_s0,
  input  logic [WSQ_REG_W-1:0] rd_s1,
  output wentry_t [DEPTH-1:0]  q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    wentry_t shifted;
    wentry_t nxt;

    if (i + 1 < DEPTH) begin : g_mid
      assign shifted = q[i+1];
    end else begin : g_tail
      assign shifted = '0;
    end

    always_comb begin
      nxt = shifted;
      if (alloc_en && (alloc_idx == LAT_W'(i))) begin
        if (use_s0) nxt.s0 = '{valid: 1'b1, rd: rd_s0};
        if (use_s1) nxt.s1 = '{valid: 1'b1, rd: rd_s1};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= nxt;
    end

    if (i + 1 < DEPTH) begin : g_chk
      // R2
      no_overwrite_s0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && use_s0 && alloc_idx == LAT_W'(i)) |-> !q[i+1].s0.valid);
      // R2
      no_overwrite_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && use_s1 && alloc_idx == LAT_W'(i)) |-> !q[i+1].s1.valid);
    end
  end
endmodule

// File: rtl/wsq_alloc.sv
module wsq_alloc
  import wsq_pkg::*;
#(
  parameter int unsigned DEPTH = 12,
  localparam int unsigned LAT_W = $clog2(DEPTH)
) (
  input  wentry_t [DEPTH-1:0]  q,
  input  logic                 iss_valid,
  input  logic                 iss_two,
  input  logic [LAT_W-1:0]     iss_lat,
  input  logic [WSQ_REG_W-1:0] iss_dst0,
  input  logic [WSQ_REG_W-1:0] iss_dst1,
  output logic                 iss_ready,
  output logic                 alloc_en,
  output logic                 use_s0,
  output logic                 use_s1,
  output logic [WSQ_REG_W-1:0] rd_s0,
  output logic [WSQ_REG_W-1:0] rd_s1
);
  wentry_t peek;
  logic    lat_ok;
  logic    free0, free1;

  always_comb begin
    peek = '0;
    for (int i = 1; i < int'(DEPTH); i++) begin
      if (int'(iss_lat) + 1 == i) peek = q[i];
    end
  end

  assign lat_ok    = (int'(iss_lat) < int'(DEPTH));
  assign free0     = !peek.s0.valid;
  assign free1     = !peek.s1.valid;
  assign iss_ready = lat_ok && (iss_two ? (free0 && free1) : (free0 || free1));
  assign alloc_en  = iss_valid && iss_ready;

  always_comb begin
    if (iss_two) begin
      use_s0 = 1'b1;
      use_s1 = 1'b1;
      rd_s0  = iss_dst0;
      rd_s1  = iss_dst1;
    end else begin
      use_s0 = free0;
      use_s1 = !free0;
      rd_s0  = iss_dst0;
      rd_s1  = iss_dst0;
    end
  end

  // R3
  always_comb begin
    bad_latency_chk: assert (!(iss_ready && !lat_ok));
  end
endmodule

// File: rtl/wsq_scoreboard.sv
module wsq_scoreboard
  import wsq_pkg::*;
#(
  parameter int unsigned DEPTH = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wentry_t [DEPTH-1:0]  q,
  output logic [WSQ_NREGS-1:0] busy_map
);
  for (genvar r = 0; r < WSQ_NREGS; r++) begin : g_reg
    always_comb begin
      busy_map[r] = 1'b0;
      for (int i = 0; i < int'(DEPTH); i++) begin
        if (q[i].s0.valid && q[i].s0.rd == WSQ_REG_W'(r)) busy_map[r] = 1'b1;
        if (q[i].s1.valid && q[i].s1.rd == WSQ_REG_W'(r)) busy_map[r] = 1'b1;
      end
    end
  end

  // R7
  head_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q[0].s0.valid |-> busy_map[q[0].s0.rd]);
endmodule

// File: rtl/wslot_sched_queue.sv
module wslot_sched_queue
  import wsq_pkg::*;
#(
  parameter int unsigned DEPTH = 12,
  localparam int unsigned LAT_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  input  logic                 iss_two,
  input  logic [LAT_W-1:0]     iss_lat,
  input  logic [WSQ_REG_W-1:0] iss_dst0,
  input  logic [WSQ_REG_W-1:0] iss_dst1,
  output logic                 iss_ready,
  output logic                 wb0_valid,
  output logic [WSQ_REG_W-1:0] wb0_reg,
  output logic                 wb1_valid,
  output logic [WSQ_REG_W-1:0] wb1_reg,
  output logic [WSQ_NREGS-1:0] busy_map
);
  wentry_t [DEPTH-1:0]  q;
  logic                 alloc_en, use_s0, use_s1;
  logic [WSQ_REG_W-1:0] rd_s0, rd_s1;

  wsq_alloc #(.DEPTH(DEPTH)) u_alloc (
    .q(q), .iss_valid(iss_valid), .iss_two(iss_two), .iss_lat(iss_lat),
    .iss_dst0(iss_dst0), .iss_dst1(iss_dst1), .iss_ready(iss_ready),
    .alloc_en(alloc_en), .use_s0(use_s0), .use_s1(use_s1),
    .rd_s0(rd_s0), .rd_s1(rd_s1)
  );

  wsq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(iss_lat),
    .use_s0(use_s0), .use_s1(use_s1), .rd_s0(rd_s0), .rd_s1(rd_s1), .q(q)
  );

  wsq_scoreboard #(.DEPTH(DEPTH)) u_sb (
    .clk(clk), .rst_n(rst_n), .q(q), .busy_map(busy_map)
  );

  assign wb0_valid = q[0].s0.valid;
  assign wb0_reg   = q[0].s0.rd;
  assign wb1_valid = q[0].s1.valid;
  assign wb1_reg   = q[0].s1.rd;

  // R9
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb1_valid |-> wb0_valid);

  // R8
  idle_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !alloc_en);
endmodule

// File: tb/tb_wslot_sched_queue.sv
module tb_wslot_sched_queue;
  localparam int DEPTH = 12;
  localparam int NR    = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0, iss_two = 1'b0;
  logic [3:0] iss_lat = '0;
  logic [5:0] iss_dst0 = '0, iss_dst1 = '0;
  logic       iss_ready, wb0_valid, wb1_valid;
  logic [5:0] wb0_reg, wb1_reg;
  logic [NR-1:0] busy_map;

  int errors = 0;
  int checks = 0;

  bit m_v [DEPTH][2];
  int m_r [DEPTH][2];

  always #5 clk = ~clk;

  wslot_sched_queue dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_two(iss_two),
    .iss_lat(iss_lat), .iss_dst0(iss_dst0), .iss_dst1(iss_dst1),
    .iss_ready(iss_ready), .wb0_valid(wb0_valid), .wb0_reg(wb0_reg),
    .wb1_valid(wb1_valid), .wb1_reg(wb1_reg), .busy_map(busy_map)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ready(input bit two, input int lat);
    bit f0, f1;
    if (lat >= DEPTH) return 1'b0;
    f0 = (lat + 1 >= DEPTH) ? 1'b1 : !m_v[lat+1][0];
    f1 = (lat + 1 >= DEPTH) ? 1'b1 : !m_v[lat+1][1];
    return two ? (f0 && f1) : (f0 || f1);
  endfunction

  function automatic logic [NR-1:0] exp_busy();
    logic [NR-1:0] b = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int s = 0; s < 2; s++)
        if (m_v[i][s]) b[m_r[i][s]] = 1'b1;
    return b;
  endfunction

  // drive one cycle, check outputs, advance model across the edge
  task automatic step(input bit v, input bit two, input int lat, input int d0, input int d1);
    bit rdy, f0;
    @(negedge clk);
    iss_valid = v; iss_two = two; iss_lat = 4'(lat);
    iss_dst0 = 6'(d0); iss_dst1 = 6'(d1);
    #1;
    rdy = exp_ready(two, lat);
    check(iss_ready == rdy, (lat >= DEPTH) ? "R3 ready" : "R2 ready", iss_ready, rdy);
    check(wb0_valid == m_v[0][0] && (!m_v[0][0] || wb0_reg == 6'(m_r[0][0])),
          "R4 R5 R6 wb0", {wb0_valid, wb0_reg}, {m_v[0][0], 6'(m_r[0][0])});
    check(wb1_valid == m_v[0][1] && (!m_v[0][1] || wb1_reg == 6'(m_r[0][1])),
          "R4 R5 R6 R9 wb1", {wb1_valid, wb1_reg}, {m_v[0][1], 6'(m_r[0][1])});
    check(busy_map == exp_busy(), "R7 busy_map", busy_map, exp_busy());
    f0 = (lat + 1 >= DEPTH) ? 1'b1 : !m_v[(lat + 1 >= DEPTH) ? 0 : lat+1][0];
    for (int i = 0; i < DEPTH; i++)
      for (int s = 0; s < 2; s++) begin
        m_v[i][s] = (i + 1 < DEPTH) ? m_v[i+1][s] : 1'b0;
        m_r[i][s] = (i + 1 < DEPTH) ? m_r[i+1][s] : 0;
      end
    if (v && rdy) begin
      if (two) begin
        m_v[lat][0] = 1; m_r[lat][0] = d0;
        m_v[lat][1] = 1; m_r[lat][1] = d1;
      end else if (f0) begin
        m_v[lat][0] = 1; m_r[lat][0] = d0;
      end else begin
        m_v[lat][1] = 1; m_r[lat][1] = d0;
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i][0] = 0; m_v[i][1] = 0; m_r[i][0] = 0; m_r[i][1] = 0;
    end
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(!wb0_valid && !wb1_valid, "R1 wb idle", {wb0_valid, wb1_valid}, 0);
    check(busy_map == '0, "R1 busy clear", busy_map, 0);
    rst_n = 1'b1;

    // R8: ready reported but nothing reserved while idle
    step(0, 0, 3, 7, 0);
    step(0, 1, 0, 9, 10);
    // R6 deepest legal latency, two slots
    step(1, 1, DEPTH-1, 1, 2);
    // R3 latency past the end
    step(1, 0, DEPTH, 3, 0);
    step(1, 1, 15, 4, 5);
    // R4 one-slot then another at the same entry one cycle later
    step(1, 0, 5, 20, 0);
    step(1, 0, 4, 21, 0);
    // entry now full: one-slot and two-slot both refused (R2)
    step(1, 0, 3, 22, 0);
    step(1, 1, 2, 23, 24);
    // R5 two-slot, then half-full entry refuses two-slot
    step(1, 0, 6, 30, 0);
    step(1, 1, 5, 31, 32);
    step(1, 0, 4, 33, 0);
    // R6 latency 0
    step(1, 0, 0, 40, 0);
    step(1, 1, 0, 41, 42);
    for (int k = 0; k < DEPTH + 2; k++) step(0, 0, 0, 0, 0);
    // R7 drained: busy clear
    check(busy_map == '0, "R7 drained", busy_map, 0);

    // random traffic with a small register pool
    for (int k = 0; k < 4000; k++) begin
      bit v   = ($urandom_range(0, 9) < 7);
      bit two = ($urandom_range(0, 3) == 0);
      int lat = ($urandom_range(0, 15) == 0) ? $urandom_range(12, 15) : $urandom_range(0, 11);
      step(v, two, lat, $urandom_range(0, 7), $urandom_range(0, 7));
    end
    for (int k = 0; k < DEPTH + 2; k++) step(0, 0, 0, 0, 0);

    summary();
    $finish;
  end
endmodule